// File: doc/BRIEF.md
# Pulse-Position Transponder Write Sequencer

The block produces the complete modulation waveform of one write command to a low-frequency read/write transponder. It controls a single pin, `mod_o`, which gates the reader field. Every symbol in the command is built from three timed segments: the pin goes high, then low, then high again. The value of the bit decides how the symbol's fixed length is split between the two high segments. All timing is counted in ticks of a base period, supplied as the one-cycle strobe `tick_i`. One tick is nominally 8 µs.

A frame is loaded with a single `start_i` strobe. The frame carries a 56-bit password, a 6-bit block address, a 4-bit byte address, an 8-bit data byte, a power-up delay and two signed trim values. One trim shifts the position of the low pulse in every symbol; the other changes its width. The block first checks that the trims leave every segment with a positive length and refuses the frame if they do not. It then computes the parity bit and plays the whole frame out. The frame starts with the power-up hold and a preamble and ends with a long access time. At the end the block raises a one-clock done pulse. Carrier generation and reading the tag's reply are handled elsewhere.

Top module: `ppm_write_seq`

## Requirements
- R1: After reset `mod_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: A 1 bit is sent as `mod_o` high for 34+p ticks, low for 6+l ticks, then high for 88-l-p ticks. Here p is `ptrim_i` and l is `wtrim_i`, both signed.
- R3: A 0 bit is sent as high for 98+p ticks, low for 6+l ticks, then high for 24-l-p ticks. Every symbol therefore lasts 128 ticks, whatever the trims.
- R4: The frame is sent in this order, with `mod_o` high unless a segment says otherwise:
  - a power-up hold of `delay_i`+4096 ticks;
  - a preamble of 4424 ticks high (the extra 70 µs is rounded up to 9 ticks), 3 ticks low and 29 ticks high;
  - 77 symbols, each field sent least-significant bit first: a 1 bit, then the 56 bits of `pwd_i` (bit 0 first), a 0 bit, `blk_i`, `byt_i`, `dat_i`, and the parity bit;
  - a closing access time of 975 ticks high.
- R5: The parity bit is 1 when `blk_i`, `byt_i` and `dat_i` together hold an odd number of ones, and 0 otherwise. Password bits do not count.
- R6: A start in idle is refused when p ≤ -34, l ≤ -6 or l+p ≥ 24. On a refusal `err_o` is high for exactly one clock and `busy_o` stays low.
- R7: `busy_o` and the first segment begin in the clock after an accepted start. `busy_o` falls on the edge that takes the last tick of the closing time. In that same edge `done_o` rises for exactly one clock and `mod_o` goes low.
- R8: While `busy_o` is high, `start_i` and changes on the frame inputs have no effect on the waveform.
- R9: Segment time advances only on clocks where `tick_i` is high.
- R10: A start presented in the clock in which `done_o` is high is accepted and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | base time tick strobe (one tick = 8 µs) |
| start_i | input | 1 | frame start strobe |
| pwd_i | input | 56 | password, bit 0 sent first |
| blk_i | input | 6 | block address |
| byt_i | input | 4 | byte address |
| dat_i | input | 8 | data byte |
| delay_i | input | 16 | extra power-up hold in ticks |
| wtrim_i | input | 8 | signed width trim l of the low pulse |
| ptrim_i | input | 8 | signed position trim p of the low pulse |
| mod_o | output | 1 | modulation enable |
| busy_o | output | 1 | frame in progress |
| done_o | output | 1 | one-clock pulse at frame end |
| err_o | output | 1 | one-clock pulse on a refused start |

## Verification
The end of a frame, which raises the done pulse, and the acceptance of a new start can fall in the same clock. The bench provokes this by driving `start_i` in exactly the cycle where `done_o` is observed high. It then checks the next frame tick by tick against its own computed waveform. The bench also lets frame time advance at half rate. It pokes `start_i` with altered data in the middle of a frame and compares every cycle against the expected level sequence. A single misplaced tick or a wrong bit therefore shows up as a mismatch.

// File: rtl/ppm_write_seq.sv
module ppm_write_seq #(
  parameter int PWR_T   = 4096,
  parameter int PRE_HI  = 4424,
  parameter int PRE_LO  = 3,
  parameter int PRE_END = 29,
  parameter int ONE_HI  = 34,
  parameter int ZERO_HI = 98,
  parameter int LOW_T   = 6,
  parameter int SYM_T   = 128,
  parameter int CLOSE_T = 975,
  parameter int DLY_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [55:0]       pwd_i,
  input  logic [5:0]        blk_i,
  input  logic [3:0]        byt_i,
  input  logic [7:0]        dat_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic signed [7:0] wtrim_i,
  input  logic signed [7:0] ptrim_i,
  output logic              mod_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int NBITS = 77;
  localparam int LAST  = NBITS + 2;
  localparam int CW    = DLY_W + 2;

  logic [NBITS-1:0]  frm_q;
  logic signed [7:0] l_q, p_q;
  logic [6:0]        item_q, nit;
  logic [1:0]        ph_q, nph;
  logic [CW-1:0]     cnt_q, len_n;
  logic              busy_q, done_q, err_q;
  logic              single, last_ph, is_bit, nb, bad, par;
  int                lv, base;

  assign par     = ^{blk_i, byt_i, dat_i};
  assign bad     = (ptrim_i <= -ONE_HI) || (wtrim_i <= -LOW_T) ||
                   (int'(wtrim_i) + int'(ptrim_i) >= SYM_T - ZERO_HI - LOW_T);
  assign single  = (item_q == 7'd0) || (item_q == 7'(LAST));
  assign last_ph = single || (ph_q == 2'd2);
  assign is_bit  = (item_q >= 7'd2) && (item_q < 7'(LAST));
  assign nit     = last_ph ? item_q + 7'd1 : item_q;
  assign nph     = last_ph ? 2'd0 : ph_q + 2'd1;
  assign nb      = (is_bit && last_ph) ? frm_q[1] : frm_q[0];

  always_comb begin
    base = nb ? ONE_HI : ZERO_HI;
    if (nit == 7'd1)
      lv = (nph == 2'd0) ? PRE_HI : (nph == 2'd1) ? PRE_LO : PRE_END;
    else if (nit == 7'(LAST))
      lv = CLOSE_T;
    else if (nph == 2'd0)
      lv = base + int'(p_q);
    else if (nph == 2'd1)
      lv = LOW_T + int'(l_q);
    else
      lv = SYM_T - base - LOW_T - int'(l_q) - int'(p_q);
    len_n = lv[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q  <= '0;
      l_q    <= '0;
      p_q    <= '0;
      item_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i && bad) begin
          err_q <= 1'b1;
        end else if (start_i) begin
          frm_q  <= {par, dat_i, byt_i, blk_i, 1'b0, pwd_i, 1'b1};
          l_q    <= wtrim_i;
          p_q    <= ptrim_i;
          item_q <= '0;
          ph_q   <= '0;
          cnt_q  <= CW'(delay_i) + CW'(PWR_T);
          busy_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (cnt_q != CW'(1)) begin
          cnt_q <= cnt_q - CW'(1);
        end else if (item_q == 7'(LAST)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          item_q <= nit;
          ph_q   <= nph;
          cnt_q  <= len_n;
          if (is_bit && last_ph) frm_q <= frm_q >> 1;
        end
      end
    end
  end

  assign mod_o  = busy_q && (ph_q != 2'd1);
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_done_on_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && !mod_o);
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !done_o);
  assert_seg_positive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
  assert_hold_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(cnt_q) && $stable(ph_q) && $stable(item_q));
  assert_low_in_symbols_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ph_q == 2'd1) |-> (item_q != 7'd0) && (item_q != 7'(LAST)));
endmodule

// File: tb/ppm_write_seq_tb.sv
module ppm_write_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [55:0] pwd = '0;
  logic [5:0] blk = '0;
  logic [3:0] byt = '0;
  logic [7:0] dat = '0;
  logic [15:0] dly = '0;
  logic signed [7:0] wt = '0, pt = '0;
  logic mod, busy, done, err;
  int checks = 0, errors = 0, cycles = 0;
  logic exp_q [0:32767];
  int total;

  always #10 clk = ~clk;

  ppm_write_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .pwd_i(pwd), .blk_i(blk), .byt_i(byt), .dat_i(dat), .delay_i(dly),
    .wtrim_i(wt), .ptrim_i(pt), .mod_o(mod), .busy_o(busy),
    .done_o(done), .err_o(err));

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic fill(input logic lvl, input int len);
    for (int i = 0; i < len; i++) begin
      exp_q[total] = lvl;
      total++;
    end
  endtask

  task automatic build(input int d, input int l, input int p);
    logic [76:0] fb;
    int h1;
    fb = {^{blk, byt, dat}, dat, byt, blk, 1'b0, pwd, 1'b1};
    total = 0;
    fill(1'b1, d + 4096);
    fill(1'b1, 4424); fill(1'b0, 3); fill(1'b1, 29);
    for (int i = 0; i < 77; i++) begin
      h1 = (fb[i] ? 34 : 98) + p;
      fill(1'b1, h1); fill(1'b0, 6 + l); fill(1'b1, 128 - h1 - 6 - l);
    end
    fill(1'b1, 975);
  endtask

  task automatic run_frame(input int d, input int l, input int p, input int div,
                           input bit poke, input bit chain, input string tag);
    int k, mism, cyc, first_k;
    logic prev;
    dly = 16'(d); wt = 8'(l); pt = 8'(p);
    build(d, l, p);
    start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; mism = 0; cyc = 0; prev = 1'b0; first_k = -1;
    forever begin
      if (prev) k++;
      if (k >= total) break;
      if (mod !== exp_q[k] || busy !== 1'b1) begin
        mism++;
        if (first_k < 0) first_k = k;
      end
      cyc++;
      prev = ((cyc % div) == 0);
      tick = prev;
      start = poke && (cyc == 3000);
      if (poke && cyc == 3000) dat = ~dat;
      @(negedge clk);
    end
    tick = 1'b0; start = 1'b0;
    chk(mism == 0, {tag, " waveform R2 R3 R4 R5 R8 R9 (first bad tick)"}, first_k, -1);
    chk(busy == 1'b0 && mod == 1'b0, {tag, " R7 busy/mod low at end"}, {busy, mod}, 0);
    chk(done == 1'b1, {tag, " R7 done pulse"}, done, 1);
    if (!chain) begin
      @(negedge clk);
      chk(done == 1'b0, {tag, " R7 done lasts one clock"}, done, 0);
    end
  endtask

  task automatic try_bad(input int l, input int p);
    wt = 8'(l); pt = 8'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R6 refused start", {err, busy}, 2);
    @(negedge clk);
    chk(err == 1'b0 && busy == 1'b0 && mod == 1'b0, "R6 err single clock", {err, busy, mod}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mod == 0, "R1 mod reset", mod, 0);
    chk(busy == 0, "R1 busy reset", busy, 0);
    chk(done == 0, "R1 done reset", done, 0);
    chk(err == 0, "R1 err reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    try_bad(0, -34);
    try_bad(-6, 0);
    try_bad(12, 12);
    pwd = 56'hA5_3C_0F_F0_96_01_7E; blk = 6'h2A; byt = 4'h5; dat = 8'hC3;
    run_frame(20, 0, 0, 1, 1'b0, 1'b1, "frame A odd parity");
    pwd = 56'h01_23_45_67_89_AB_CD; blk = 6'h03; byt = 4'h1; dat = 8'h81;
    run_frame(5, 5, -10, 1, 1'b1, 1'b0, "frame B R10 start on done, R8 poke");
    pwd = 56'hFF_00_FF_00_55_AA_11; blk = 6'h3F; byt = 4'hF; dat = 8'h00;
    run_frame(0, 10, 13, 2, 1'b0, 1'b0, "frame C half-rate tick");
    pwd = 56'h80_40_20_10_08_04_02; blk = 6'h00; byt = 4'h0; dat = 8'hFE;
    run_frame(300, -5, -33, 1, 1'b0, 1'b0, "frame D extreme trims");
    summary();
  end
endmodule